// File: doc/BRIEF.md
# Low-Power Mode and Wake-Up Sequencer

This block decides, cycle by cycle, whether a small controller is running, idling, stopped or held in back-up, and drives the matching oscillator enable, CPU clock enable, peripheral clock enable and system reset. It runs on a free-running oscillator clock. A raw reset pin and raw external interrupt lines first pass through synchronising noise filters. A level-valid supply-low flag is taken as it arrives.

In back-up the oscillator is off and the system is held in reset. When the cause clears, the oscillator restarts and reset is held through a long fixed stabilisation wait. A stop is left through an enabled interrupt. That wait is selectable and shorter. The CPU clock enable comes from a prescaler that divides the oscillator by six times a selectable factor. A new factor is taken up only at a divided-clock boundary.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: While the filtered reset pin is low, or in the cycle after `lvdLow` is high, the block is in back-up: `oscEn`=0, `cpuClkEn`=0, `periphClkEn`=0, `sysRst`=1. Back-up is the state after `porN` reset.
- R2: When the back-up cause clears, `oscEn` rises with `sysRst` still 1. `sysRst` stays 1 with the oscillator on for exactly 2^(16-WAIT_SHIFT) cycles, and then the block runs.
- R3: A one-cycle `stopReq` in run, with no enabled filtered interrupt pending, enters stop: `oscEn`, `periphClkEn` and `cpuClkEn` are 0 and `sysRst` is 0.
- R4: A `stopReq` that arrives while an enabled filtered interrupt is pending is ignored, and the block stays in run.
- R5: In stop, an enabled filtered interrupt turns the oscillator on with clocks still gated for exactly 2^(e-WAIT_SHIFT) cycles, and then the block runs. Here e is 8, 11, 14 or 16 for `waitSel` 0, 1, 2 or 3.
- R6: `idleReq` in run enters idle: `oscEn`=1, `periphClkEn`=1, no `cpuClkEn` pulses. An interrupt line whose `irqEn` bit is 0 does not wake the block. An enabled one returns it to run without a wait.
- R7: In run, `cpuClkEn` is a one-cycle pulse every 6·n cycles. n is 1, 2, 8 or 16 for `divSel` 0, 1, 2 or 3.
- R8: A change of `divSel` takes effect only at the next `cpuClkEn` pulse, so the interval already in progress keeps its old length.
- R9: A pulse on an interrupt line or a low pulse on the reset pin that lasts fewer than FILT_LEN cycles has no effect.
- R10: In run, `oscEn`=1, `periphClkEn`=1 and `sysRst`=0.
- R11: If `stopReq` and `idleReq` arrive in the same cycle, stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| porN | input | 1 | Power-on reset of the block's flops, active low, asynchronous |
| rstPinN | input | 1 | Raw reset / back-up pin, active low |
| lvdLow | input | 1 | Supply-low flag, level valid |
| stopReq | input | 1 | Stop request pulse |
| idleReq | input | 1 | Idle request pulse |
| extIrq | input | NIRQ | Raw external interrupt lines, active high |
| irqEn | input | NIRQ | Per-line wake enable |
| waitSel | input | 2 | Interrupt-release wait select |
| divSel | input | 2 | CPU clock divide select |
| oscEn | output | 1 | Oscillator enable |
| cpuClkEn | output | 1 | CPU clock enable pulse |
| periphClkEn | output | 1 | Peripheral clock enable |
| sysRst | output | 1 | System reset |

## Verification
On every cycle the assertions check the following. A supply-low flag forces back-up in the next cycle. A CPU clock pulse occurs only while the oscillator and peripherals run and reset is off. The oscillator never stops while any clock is enabled. Reset is released only with the oscillator on. Two CPU pulses are never closer than six cycles. The exact lengths of the two stabilisation waits, the divide ratios and their boundary-timed change, the ignored stop with a pending interrupt, the masked wake in idle and the rejection of short glitches are shown only by the bench's scenarios. These mix directed cases with random choices of wait and divide settings.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_IDLE, ST_STOP, ST_BACKUP, ST_WRST, ST_WINT
  } pwrState_t;

  typedef struct packed {
    logic loadRstWait;
    logic loadIntWait;
    logic runActive;
  } ctlStrobe_t;
endpackage

// File: rtl/pwr_filter.sv
module pwr_filter #(
  parameter int   FILT_LEN = 4,
  parameter logic RST_VAL  = 1'b0
) (
  input  logic clk,
  input  logic porN,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);
  logic sync1, sync2;
  logic [CW-1:0] agree;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      sync1 <= RST_VAL;
      sync2 <= RST_VAL;
      dout  <= RST_VAL;
      agree <= '0;
    end else begin
      sync1 <= din;
      sync2 <= sync1;
      if (sync2 != dout) begin
        if (agree == CW'(FILT_LEN - 1)) begin
          dout  <= sync2;
          agree <= '0;
        end else begin
          agree <= agree + 1'b1;
        end
      end else begin
        agree <= '0;
      end
    end
  end
endmodule

// File: rtl/pwr_datapath.sv
module pwr_datapath
  import pwr_pkg::*;
#(
  parameter int NIRQ       = 4,
  parameter int FILT_LEN   = 4,
  parameter int WAIT_SHIFT = 0,
  parameter int BASE_DIV   = 6
) (
  input  logic            clk,
  input  logic            porN,
  input  logic            rstPinN,
  input  logic [NIRQ-1:0] extIrq,
  input  logic [NIRQ-1:0] irqEn,
  input  logic [1:0]      waitSel,
  input  logic [1:0]      divSel,
  input  ctlStrobe_t      strobe,
  output logic            rstFilt,
  output logic            wakePend,
  output logic            waitDone,
  output logic            cpuTick
);
  localparam int RST_EXP = 16;
  localparam int WCNT_W  = RST_EXP - WAIT_SHIFT;
  localparam int DIV_W   = $clog2(BASE_DIV * 16);

  logic [NIRQ-1:0]   irqFilt;
  logic [WCNT_W-1:0] waitCnt;
  logic [DIV_W-1:0]  divCnt;
  logic [1:0]        divCur;

  pwr_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b0)) u_rstFilt (
    .clk(clk), .porN(porN), .din(rstPinN), .dout(rstFilt)
  );

  for (genvar i = 0; i < NIRQ; i++) begin : g_irqFilt
    pwr_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b0)) u_irqFilt (
      .clk(clk), .porN(porN), .din(extIrq[i]), .dout(irqFilt[i])
    );
  end

  assign wakePend = |(irqFilt & irqEn);

  function automatic logic [WCNT_W-1:0] intLast(input logic [1:0] sel);
    int e;
    case (sel)
      2'd0:    e = 8;
      2'd1:    e = 11;
      2'd2:    e = 14;
      default: e = 16;
    endcase
    return WCNT_W'((1 << (e - WAIT_SHIFT)) - 1);
  endfunction

  function automatic logic [DIV_W-1:0] divLast(input logic [1:0] sel);
    int n;
    case (sel)
      2'd0:    n = 1;
      2'd1:    n = 2;
      2'd2:    n = 8;
      default: n = 16;
    endcase
    return DIV_W'(BASE_DIV * n - 1);
  endfunction

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      waitCnt <= '0;
    end else if (strobe.loadRstWait) begin
      waitCnt <= '1;
    end else if (strobe.loadIntWait) begin
      waitCnt <= intLast(waitSel);
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end
  assign waitDone = (waitCnt == '0);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      divCnt <= '0;
      divCur <= 2'd0;
    end else if (!strobe.runActive) begin
      divCnt <= '0;
      divCur <= divSel;
    end else if (divCnt == divLast(divCur)) begin
      divCnt <= '0;
      divCur <= divSel;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
  assign cpuTick = strobe.runActive && (divCnt == divLast(divCur));
endmodule

// File: rtl/pwr_ctrl.sv
module pwr_ctrl
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       rstFilt,
  input  logic       lvdLow,
  input  logic       stopReq,
  input  logic       idleReq,
  input  logic       wakePend,
  input  logic       waitDone,
  output ctlStrobe_t strobe,
  output logic       oscEn,
  output logic       periphEn,
  output logic       sysRst
);
  pwrState_t state, nextState;
  logic backupCond;

  assign backupCond = !rstFilt || lvdLow;

  always_comb begin
    nextState = state;
    if (backupCond) begin
      nextState = ST_BACKUP;
    end else begin
      case (state)
        ST_BACKUP: nextState = ST_WRST;
        ST_WRST:   if (waitDone) nextState = ST_RUN;
        ST_RUN: begin
          if (stopReq) begin
            if (!wakePend) nextState = ST_STOP;
          end else if (idleReq) begin
            nextState = ST_IDLE;
          end
        end
        ST_IDLE:   if (wakePend) nextState = ST_RUN;
        ST_STOP:   if (wakePend) nextState = ST_WINT;
        ST_WINT:   if (waitDone) nextState = ST_RUN;
        default:   nextState = ST_BACKUP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_BACKUP;
    else       state <= nextState;
  end

  assign strobe.loadRstWait = (nextState == ST_WRST) && (state != ST_WRST);
  assign strobe.loadIntWait = (nextState == ST_WINT) && (state != ST_WINT);
  assign strobe.runActive   = (state == ST_RUN);

  assign oscEn    = (state == ST_RUN) || (state == ST_IDLE) ||
                    (state == ST_WRST) || (state == ST_WINT);
  assign periphEn = (state == ST_RUN) || (state == ST_IDLE);
  assign sysRst   = (state == ST_BACKUP) || (state == ST_WRST);
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_pkg::*;
#(
  parameter int NIRQ       = 4,
  parameter int FILT_LEN   = 4,
  parameter int WAIT_SHIFT = 0,
  parameter int BASE_DIV   = 6
) (
  input  logic            clk,
  input  logic            porN,
  input  logic            rstPinN,
  input  logic            lvdLow,
  input  logic            stopReq,
  input  logic            idleReq,
  input  logic [NIRQ-1:0] extIrq,
  input  logic [NIRQ-1:0] irqEn,
  input  logic [1:0]      waitSel,
  input  logic [1:0]      divSel,
  output logic            oscEn,
  output logic            cpuClkEn,
  output logic            periphClkEn,
  output logic            sysRst
);
  ctlStrobe_t strobe;
  logic rstFilt, wakePend, waitDone;

  pwr_datapath #(
    .NIRQ(NIRQ), .FILT_LEN(FILT_LEN), .WAIT_SHIFT(WAIT_SHIFT), .BASE_DIV(BASE_DIV)
  ) u_dp (
    .clk(clk), .porN(porN), .rstPinN(rstPinN), .extIrq(extIrq), .irqEn(irqEn),
    .waitSel(waitSel), .divSel(divSel), .strobe(strobe), .rstFilt(rstFilt),
    .wakePend(wakePend), .waitDone(waitDone), .cpuTick(cpuClkEn)
  );

  pwr_ctrl u_ctl (
    .clk(clk), .porN(porN), .rstFilt(rstFilt), .lvdLow(lvdLow),
    .stopReq(stopReq), .idleReq(idleReq), .wakePend(wakePend),
    .waitDone(waitDone), .strobe(strobe), .oscEn(oscEn),
    .periphEn(periphClkEn), .sysRst(sysRst)
  );
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk #(
  parameter int BASE_DIV = 6
) (
  input logic clk,
  input logic porN,
  input logic lvdLow,
  input logic oscEn,
  input logic cpuClkEn,
  input logic periphClkEn,
  input logic sysRst
);
  logic [7:0] gapCnt;
  logic       havePulse;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      gapCnt    <= '0;
      havePulse <= 1'b0;
    end else if (cpuClkEn) begin
      gapCnt    <= '0;
      havePulse <= 1'b1;
    end else if (gapCnt != 8'hFF) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  AST_LVD_FORCES_BACKUP: assert property (@(posedge clk) disable iff (!porN)
    lvdLow |=> (!oscEn && sysRst && !periphClkEn)); // R1

  AST_RESET_RELEASE_OSC_ON: assert property (@(posedge clk) disable iff (!porN)
    $fell(sysRst) |-> oscEn); // R2

  AST_OSC_OFF_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!porN)
    !oscEn |-> (!periphClkEn && !cpuClkEn)); // R3

  AST_CPU_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (!porN)
    cpuClkEn |-> (oscEn && periphClkEn && !sysRst)); // R10

  AST_CPU_MIN_GAP: assert property (@(posedge clk) disable iff (!porN)
    (cpuClkEn && havePulse) |-> (gapCnt >= 8'(BASE_DIV - 1))); // R7
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk #(.BASE_DIV(BASE_DIV)) u_chk (
  .clk(clk), .porN(porN), .lvdLow(lvdLow), .oscEn(oscEn),
  .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .sysRst(sysRst)
);

// File: tb/pwr_wake_ctrl_tb.sv
module pwr_wake_ctrl_tb;
  localparam int NIRQ  = 4;
  localparam int FILT  = 4;
  localparam int SHIFT = 6;

  logic clk = 1'b0;
  logic porN, rstPinN, lvdLow, stopReq, idleReq;
  logic [NIRQ-1:0] extIrq, irqEn;
  logic [1:0] waitSel, divSel;
  logic oscEn, cpuClkEn, periphClkEn, sysRst;

  int nTests = 0;
  int nFail  = 0;

  always #4 clk = ~clk;

  pwr_wake_ctrl #(.NIRQ(NIRQ), .FILT_LEN(FILT), .WAIT_SHIFT(SHIFT)) u_dut (
    .clk(clk), .porN(porN), .rstPinN(rstPinN), .lvdLow(lvdLow),
    .stopReq(stopReq), .idleReq(idleReq), .extIrq(extIrq), .irqEn(irqEn),
    .waitSel(waitSel), .divSel(divSel), .oscEn(oscEn), .cpuClkEn(cpuClkEn),
    .periphClkEn(periphClkEn), .sysRst(sysRst)
  );

  function automatic int expPeriod(input int s);
    case (s)
      0: return 6;
      1: return 12;
      2: return 48;
      default: return 96;
    endcase
  endfunction

  function automatic int expIntWait(input int s);
    case (s)
      0: return 1 << (8 - SHIFT);
      1: return 1 << (11 - SHIFT);
      2: return 1 << (14 - SHIFT);
      default: return 1 << (16 - SHIFT);
    endcase
  endfunction

  localparam int RST_WAIT = 1 << (16 - SHIFT);

  task automatic chkEq(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic nextPulse(output int waited);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!cpuClkEn && waited < 400);
  endtask

  task automatic measureRstWait(output int len);
    int guard = 0;
    len = 0;
    while (!oscEn && guard < 200) begin @(negedge clk); guard++; end
    while (oscEn && sysRst && len < 5000) begin len++; @(negedge clk); end
  endtask

  task automatic enterStop();
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
  endtask

  task automatic wakeFromStop(input int ws, output int len);
    int guard = 0;
    waitSel = 2'(ws);
    extIrq[0] = 1'b1;
    len = 0;
    while (!oscEn && guard < 100) begin @(negedge clk); guard++; end
    while (oscEn && !periphClkEn && len < 5000) begin len++; @(negedge clk); end
  endtask

  task automatic dropIrq();
    extIrq = '0;
    tick(FILT + 6);
  endtask

  task automatic periodCheck(input int s);
    int w, d;
    divSel = 2'(s);
    nextPulse(w);
    nextPulse(d);
    chkEq($sformatf("R7 divide period sel=%0d", s), d, expPeriod(s));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int len, w, d, cnt, ws;
    void'($urandom(32'd4242));
    porN = 1'b0; rstPinN = 1'b0; lvdLow = 1'b0; stopReq = 1'b0; idleReq = 1'b0;
    extIrq = '0; irqEn = 4'b0001; waitSel = 2'd0; divSel = 2'd0;
    tick(3);
    // R1: reset state is back-up
    chkEq("R1 reset oscEn", int'(oscEn), 0);
    chkEq("R1 reset sysRst", int'(sysRst), 1);
    porN = 1'b1;
    tick(4);
    chkEq("R1 pin low keeps back-up", int'(sysRst && !oscEn), 1);

    // R2: reset release wait
    rstPinN = 1'b1;
    measureRstWait(len);
    chkEq("R2 reset release wait", len, RST_WAIT);
    chkEq("R10 run enables", int'(oscEn && periphClkEn && !sysRst), 1);

    // R7: each divide ratio
    for (int s = 0; s < 4; s++) periodCheck(s);

    // R8: change mid-interval waits for the boundary
    divSel = 2'd3;
    nextPulse(w);
    nextPulse(w);
    @(negedge clk);
    divSel = 2'd0;
    nextPulse(d);
    chkEq("R8 old interval completes", d, expPeriod(3) - 1);
    nextPulse(d);
    chkEq("R8 new ratio after boundary", d, expPeriod(0));

    // R3: stop entry
    enterStop();
    chkEq("R3 stop oscEn off", int'(oscEn), 0);
    chkEq("R3 stop clocks off", int'(periphClkEn || cpuClkEn || sysRst), 0);

    // R9: short interrupt glitch does not wake
    extIrq[0] = 1'b1;
    tick(FILT - 1);
    extIrq[0] = 1'b0;
    tick(12);
    chkEq("R9 irq glitch ignored", int'(oscEn), 0);

    // R5: interrupt release, directed longest wait
    wakeFromStop(3, len);
    chkEq("R5 wake wait sel=3", len, expIntWait(3));
    chkEq("R10 run after wake", int'(periphClkEn && !sysRst), 1);
    dropIrq();

    // R5 and R7 with random settings
    for (int i = 0; i < 4; i++) begin
      ws = int'($urandom % 4);
      enterStop();
      chkEq("R3 stop entered", int'(oscEn), 0);
      wakeFromStop(ws, len);
      chkEq($sformatf("R5 wake wait sel=%0d", ws), len, expIntWait(ws));
      dropIrq();
      periodCheck(int'($urandom % 4));
    end

    // R4: stop ignored when an enabled interrupt is pending
    divSel = 2'd0;
    extIrq[0] = 1'b1;
    tick(FILT + 6);
    enterStop();
    chkEq("R4 stop ignored oscEn", int'(oscEn && periphClkEn), 1);
    cnt = 0;
    repeat (20) begin @(negedge clk); if (cpuClkEn) cnt++; end
    chkEq("R4 cpu pulses continue", int'(cnt > 0), 1);
    dropIrq();

    // R6: idle, masked wake ignored, enabled wake returns to run
    idleReq = 1'b1;
    @(negedge clk);
    idleReq = 1'b0;
    chkEq("R6 idle osc/periph", int'(oscEn && periphClkEn), 1);
    extIrq[1] = 1'b1;
    cnt = 0;
    repeat (60) begin @(negedge clk); if (cpuClkEn) cnt++; end
    chkEq("R6 no cpu pulse in idle, masked line", cnt, 0);
    extIrq[0] = 1'b1;
    nextPulse(w);
    chkEq("R6 enabled wake resumes cpu", int'(w < FILT + 20), 1);
    dropIrq();

    // R11: stop beats idle
    stopReq = 1'b1; idleReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0; idleReq = 1'b0;
    chkEq("R11 stop wins", int'(oscEn), 0);
    wakeFromStop(0, len);
    chkEq("R5 wake wait sel=0", len, expIntWait(0));
    dropIrq();

    // R9: short reset glitch ignored
    rstPinN = 1'b0;
    tick(FILT - 1);
    rstPinN = 1'b1;
    cnt = 0;
    repeat (12) begin @(negedge clk); if (sysRst) cnt++; end
    chkEq("R9 reset glitch ignored", cnt, 0);

    // R1: supply-low flag
    lvdLow = 1'b1;
    @(negedge clk);
    chkEq("R1 lvd back-up", int'(!oscEn && sysRst && !periphClkEn), 1);
    tick(5);
    lvdLow = 1'b0;
    measureRstWait(len);
    chkEq("R2 release after lvd", len, RST_WAIT);

    // R1: long reset pin low
    rstPinN = 1'b0;
    tick(FILT + 6);
    chkEq("R1 pin low back-up", int'(!oscEn && sysRst), 1);
    rstPinN = 1'b1;
    measureRstWait(len);
    chkEq("R2 release after pin", len, RST_WAIT);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule